// File: doc/BRIEF.md
# Newton-Raphson Reciprocal Divider

This block divides a signed 32-bit dividend by a signed 16-bit divisor. It does not run a digit-by-digit recurrence. It first forms an approximation of the reciprocal of the divisor and then multiplies the dividend by that reciprocal. The magnitude of the divisor is shifted left until its top bit is set, which places it in [0.5, 1) as an unsigned fraction. A first reciprocal guess is then read off a piecewise-linear chord of 1/d. The segment is chosen by the four fraction bits just below the leading one, and the position inside the segment comes from the remaining bits. The guess is refined a fixed number of times with z <- z(2 - d·z). The dividend magnitude is multiplied by the refined reciprocal and shifted back by the normalisation count. The sign is applied last.

All multiplications go through one 16x16 unsigned multiplier, one product per cycle. The operation therefore runs through a short fixed schedule:
- one cycle to load the operands,
- one cycle for the seed,
- two cycles per refinement,
- two cycles for the 32x16 final product,
- one cycle to form the result.

With the default three refinements, a result appears 10 cycles after the start is accepted. A caller pulses `start` while `busy` is low and waits for the one-cycle `done` pulse. `quotient` and `div_zero` then stay valid until the next result.

Top module: `nr_recip_div`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done` and `div_zero` are 0 and `quotient` is 0.
- R2: A high `start` while `busy` is low is accepted at that rising edge. `busy` is 1 from the next cycle until the result. `done` is high for exactly one cycle, 4 + 2·ITERS cycles (10 by default) after the accepting edge, and `busy` is 0 when `done` is 1.
- R3: For a nonzero divisor, `quotient` (signed 32-bit two's complement) differs from the dividend/divisor quotient truncated toward zero by at most |exact| / 4096 + 2.
- R4: Operands are two's complement. The magnitudes are divided and the result is negated when exactly one operand is negative, so the R3 bound holds for every sign combination. This includes a dividend of -2^31.
- R5: A zero divisor gives `div_zero` = 1 and `quotient` = 0x7FFFFFFF, with the same latency and `done` pulse as R2.
- R6: For a nonzero divisor, `div_zero` is 0 with the result.
- R7: A `start` seen while `busy` is 1 is ignored. The running division keeps its captured operands and produces exactly one `done`.
- R8: `quotient` and `div_zero` change only in the cycle in which `done` is 1, and hold their value between results.
- R9: The extreme divisors 1, -1, 32767 and -32768 still meet the R3 bound.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request a division; accepted only while not busy |
| dividend | input | 32 | Signed dividend, captured at the accepting edge |
| divisor | input | 16 | Signed divisor, captured at the accepting edge |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse marking a new result |
| quotient | output | 32 | Signed approximate quotient, held until the next result |
| div_zero | output | 1 | The last result came from a zero divisor |

## Verification
The assertions assume that the block leaves reset before the first request. They also assume that `start` is a level sampled at rising edges with no meaning while `busy` is high. The latency check and the hold check both rest on these two points. The stimulus changes `start`, `dividend` and `divisor` only on falling edges, and it issues each new request only after the previous `done` has been observed. The one exception is the deliberate mid-operation request for R7. Expected quotients are computed as exact 64-bit truncated divisions and compared against the R3 error bound rather than bit for bit, because the reciprocal carries about 15 bits of accuracy.

// File: rtl/nr_div_pkg.sv
package nr_div_pkg;

  localparam int DVD_W = 32;
  localparam int DVS_W = 16;
  localparam int ACC_W = DVD_W + DVS_W;
  localparam int CNT_W = $clog2(DVS_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEED,
    ST_ITA,
    ST_ITB,
    ST_FLO,
    ST_FHI,
    ST_FIN
  } nr_state_e;

  // Reciprocal of the k-th segment boundary of [0.5,1), as unsigned Q1.15, capped at all-ones.
  function automatic logic [15:0] recip_knot(input int seg_bits, input int k);
    int v;
    v = (1 << (16 + seg_bits)) / ((1 << seg_bits) + k);
    if (v > 65535) v = 65535;
    return 16'(v);
  endfunction

endpackage

// File: rtl/nr_div_lzc.sv
module nr_div_lzc #(
  parameter int W  = 16,
  parameter int CW = 5
) (
  input  logic [W-1:0]  val,
  output logic [CW-1:0] zeros
);
  always_comb begin
    zeros = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (val[i]) zeros = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/nr_div_seed.sv
module nr_div_seed #(
  parameter int SEG_BITS = 4,
  localparam int SEGS   = 1 << SEG_BITS,
  localparam int FRAC_W = 15 - SEG_BITS
) (
  input  logic [14:0]       norm_low,
  output logic [15:0]       base,
  output logic [15:0]       drop,
  output logic [FRAC_W-1:0] frac
);
  import nr_div_pkg::*;

  logic [15:0]         knot [SEGS+1];
  logic [SEG_BITS-1:0] idx;
  logic [SEG_BITS:0]   idx_nx;

  for (genvar g = 0; g <= SEGS; g++) begin : g_knot
    assign knot[g] = recip_knot(SEG_BITS, g);
  end

  assign idx    = norm_low[14 -: SEG_BITS];
  assign idx_nx = {1'b0, idx} + 1'b1;
  assign frac   = norm_low[FRAC_W-1:0];
  assign base   = knot[idx];
  assign drop   = knot[idx] - knot[idx_nx];
endmodule

// File: rtl/nr_div_fsm.sv
module nr_div_fsm #(
  parameter int ITERS = 3,
  localparam int IT_W = $clog2(ITERS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  output nr_div_pkg::nr_state_e state
);
  import nr_div_pkg::*;

  nr_state_e state_d;
  logic [IT_W-1:0] iter_q, iter_d;

  always_comb begin
    state_d = state;
    iter_d  = iter_q;
    case (state)
      ST_IDLE: if (start) state_d = ST_SEED;
      ST_SEED: begin state_d = ST_ITA; iter_d = '0; end
      ST_ITA:  state_d = ST_ITB;
      ST_ITB: begin
        if (iter_q == IT_W'(ITERS - 1)) state_d = ST_FLO;
        else begin
          state_d = ST_ITA;
          iter_d  = iter_q + 1'b1;
        end
      end
      ST_FLO:  state_d = ST_FHI;
      ST_FHI:  state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      iter_q <= '0;
    end else begin
      state  <= state_d;
      iter_q <= iter_d;
    end
  end
endmodule

// File: rtl/nr_recip_div.sv
module nr_recip_div #(
  parameter int ITERS    = 3,
  parameter int SEG_BITS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] dividend,
  input  logic [15:0] divisor,
  output logic        busy,
  output logic        done,
  output logic [31:0] quotient,
  output logic        div_zero
);
  import nr_div_pkg::*;

  localparam int FRAC_W = 15 - SEG_BITS;

  // reset: asserted asynchronously, released through two flops
  logic rst_s1, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_core_n <= rst_s1;
    end
  end

  nr_state_e state;
  logic      accept;

  assign busy   = (state != ST_IDLE);
  assign accept = (state == ST_IDLE) && start;

  nr_div_fsm #(.ITERS(ITERS)) u_fsm (
    .clk   (clk),
    .rst_n (rst_core_n),
    .start (start),
    .state (state)
  );

  // operand conditioning
  logic [DVD_W-1:0] x_mag;
  logic [DVS_W-1:0] y_mag;
  logic [CNT_W-1:0] y_lz;

  assign x_mag = dividend[DVD_W-1] ? (~dividend + 1'b1) : dividend;
  assign y_mag = divisor[DVS_W-1]  ? (~divisor + 1'b1)  : divisor;

  nr_div_lzc #(.W(DVS_W), .CW(CNT_W)) u_lzc (
    .val   (y_mag),
    .zeros (y_lz)
  );

  // registers
  logic [DVD_W-1:0] xm_q;
  logic [DVS_W-1:0] yn_q, z_q, e_q;
  logic [CNT_W-1:0] lz_q;
  logic             neg_q, zero_q;
  logic [ACC_W-1:0] acc_q;
  logic [DVS_W-1:0] z_d, e_d;
  logic [ACC_W-1:0] acc_d;
  logic [DVD_W-1:0] quo_d;
  logic             ld_z, ld_e, ld_acc, ld_out;

  // seed table
  logic [15:0]       seed_base, seed_drop;
  logic [FRAC_W-1:0] seed_frac;

  nr_div_seed #(.SEG_BITS(SEG_BITS)) u_seed (
    .norm_low (yn_q[14:0]),
    .base     (seed_base),
    .drop     (seed_drop),
    .frac     (seed_frac)
  );

  // the single shared multiplier
  logic [15:0] mul_a, mul_b;
  logic [31:0] mul_p;

  always_comb begin
    mul_a = '0;
    mul_b = '0;
    case (state)
      ST_SEED: begin mul_a = seed_drop;   mul_b = 16'(seed_frac); end
      ST_ITA:  begin mul_a = yn_q;        mul_b = z_q;            end
      ST_ITB:  begin mul_a = z_q;         mul_b = e_q;            end
      ST_FLO:  begin mul_a = xm_q[15:0];  mul_b = z_q;            end
      ST_FHI:  begin mul_a = xm_q[31:16]; mul_b = z_q;            end
      default: ;
    endcase
  end

  assign mul_p = mul_a * mul_b;

  // next-state datapath
  logic [16:0] e_wide, z_wide;
  logic [5:0]  out_sh;
  logic [31:0] out_mag;

  assign e_wide  = 17'((34'h1_0000_0000 - {2'b00, mul_p}) >> 16);
  assign z_wide  = 17'(mul_p >> 15);
  assign out_sh  = 6'd31 - 6'(lz_q);
  assign out_mag = 32'(acc_q >> out_sh);

  always_comb begin
    ld_z   = (state == ST_SEED) || (state == ST_ITB);
    ld_e   = (state == ST_ITA);
    ld_acc = (state == ST_FLO) || (state == ST_FHI);
    ld_out = (state == ST_FIN);

    if (state == ST_SEED) z_d = seed_base - 16'(mul_p >> FRAC_W);
    else                  z_d = z_wide[16] ? 16'hFFFF : z_wide[15:0];

    e_d = e_wide[16] ? 16'hFFFF : e_wide[15:0];

    if (state == ST_FLO) acc_d = ACC_W'(mul_p);
    else                 acc_d = acc_q + {mul_p, 16'h0000};

    if (zero_q)     quo_d = 32'h7FFF_FFFF;
    else if (neg_q) quo_d = ~out_mag + 1'b1;
    else            quo_d = out_mag;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      xm_q     <= '0;
      yn_q     <= '0;
      lz_q     <= '0;
      neg_q    <= 1'b0;
      zero_q   <= 1'b0;
      z_q      <= '0;
      e_q      <= '0;
      acc_q    <= '0;
      quotient <= '0;
      div_zero <= 1'b0;
      done     <= 1'b0;
    end else begin
      if (accept) begin
        xm_q   <= x_mag;
        yn_q   <= y_mag << y_lz;
        lz_q   <= y_lz;
        neg_q  <= dividend[DVD_W-1] ^ divisor[DVS_W-1];
        zero_q <= (divisor == '0);
      end
      if (ld_z)   z_q   <= z_d;
      if (ld_e)   e_q   <= e_d;
      if (ld_acc) acc_q <= acc_d;
      if (ld_out) begin
        quotient <= quo_d;
        div_zero <= zero_q;
      end
      done <= ld_out;
    end
  end
endmodule

// File: rtl/nr_recip_div_chk.sv
module nr_recip_div_chk #(
  parameter int ITERS = 3,
  localparam int LAT  = 4 + 2 * ITERS
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [31:0] quotient,
  input logic        div_zero
);
  logic [7:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             run_cnt <= '0;
    else if (start && !busy) run_cnt <= '0;
    else if (busy)          run_cnt <= run_cnt + 1'b1;
  end

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R2
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cnt == 8'(LAT)));

  // R5
  zero_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_zero) |-> (quotient == 32'h7FFF_FFFF));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(div_zero)));
endmodule

bind nr_recip_div nr_recip_div_chk #(.ITERS(ITERS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .quotient (quotient),
  .div_zero (div_zero)
);

// File: tb/nr_recip_div_bench.sv
`timescale 1ns/1ps
module nr_recip_div_bench;
  localparam int ITERS = 3;
  localparam int LAT   = 4 + 2 * ITERS;
  localparam int NV    = 14;

  localparam logic [31:0] VX [NV] = '{
    32'd100, -32'sd100, 32'd100, -32'sd100, 32'h7FFF_FFFF, 32'h8000_0000,
    32'h8000_0000, 32'd123456789, -32'sd987654321, 32'd1000000, 32'd5,
    32'd65535, 32'h7FFF_FFFF, -32'sd1};
  localparam logic [15:0] VY [NV] = '{
    16'd7, 16'd7, -16'sd7, -16'sd7, 16'd1, 16'd1,
    16'hFFFF, 16'd32767, 16'h8000, 16'd3, 16'd100,
    16'd255, 16'd12345, 16'd2};

  logic        clk, rst_n, start;
  logic [31:0] dividend;
  logic [15:0] divisor;
  logic        busy, done, div_zero;
  logic [31:0] quotient;

  int errors = 0;
  int checks = 0;
  int got_lat;
  logic [31:0] got_q;
  logic        got_dz;

  nr_recip_div #(.ITERS(ITERS)) u_nr_recip_div (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .busy(busy), .done(done), .quotient(quotient),
    .div_zero(div_zero));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_div(input logic [31:0] x, input logic [15:0] y, input bit inject);
    @(negedge clk);
    dividend = x; divisor = y; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    dividend = 32'd77; divisor = 16'd9;
    check(busy == 1'b1, "R2", "busy after accept", longint'(busy), 1);
    got_lat = 0;
    while (!done && got_lat < 40) begin
      @(posedge clk);
      got_lat++;
      @(negedge clk);
      if (inject) begin
        start = (got_lat == 3);
        if (got_lat == 3) begin dividend = 32'd999; divisor = 16'd1; end
      end
    end
    start  = 1'b0;
    got_q  = quotient;
    got_dz = div_zero;
  endtask

  task automatic check_value(input logic [31:0] x, input logic [15:0] y, input string req);
    longint ex, diff, tol;
    ex   = longint'($signed(x)) / longint'($signed(y));
    diff = longint'($signed(got_q)) - ex;
    if (diff < 0) diff = -diff;
    tol  = ((ex < 0) ? -ex : ex) / 4096 + 2;
    check(diff <= tol, req, "quotient", longint'($signed(got_q)), ex);
    check(got_dz == 1'b0, "R6", "div_zero", longint'(got_dz), 0);
    check(got_lat == LAT, "R2", "latency", got_lat, LAT);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; dividend = '0; divisor = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values while held
    check({busy, done, div_zero} == 3'b000, "R1", "flags in reset", longint'({busy, done, div_zero}), 0);
    check(quotient == 32'd0, "R1", "quotient in reset", longint'(quotient), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({busy, done, div_zero} == 3'b000, "R1", "flags after reset", longint'({busy, done, div_zero}), 0);

    // vector table: R3 / R4 (signed) / R9 (extreme divisors)
    for (int i = 0; i < NV; i++) begin
      string req;
      run_div(VX[i], VY[i], 1'b0);
      if (VY[i] == 16'd1 || VY[i] == 16'hFFFF || VY[i] == 16'd32767 || VY[i] == 16'h8000)
        req = "R9";
      else if (VX[i][31] || VY[i][15]) req = "R4";
      else req = "R3";
      check_value(VX[i], VY[i], req);
    end

    // R5: zero divisor
    run_div(32'd12345, 16'd0, 1'b0);
    check(got_dz == 1'b1, "R5", "div_zero pos", longint'(got_dz), 1);
    check(got_q == 32'h7FFF_FFFF, "R5", "saturated pos", longint'(got_q), 64'h7FFF_FFFF);
    check(got_lat == LAT, "R5", "latency", got_lat, LAT);
    run_div(-32'sd5, 16'd0, 1'b0);
    check(got_q == 32'h7FFF_FFFF && got_dz, "R5", "saturated neg", longint'(got_q), 64'h7FFF_FFFF);

    // R6: flag clears on the next nonzero divisor
    run_div(32'd1000, 16'd10, 1'b0);
    check_value(32'd1000, 16'd10, "R3");

    // R8: result holds between results
    repeat (6) @(negedge clk);
    check(quotient == got_q, "R8", "held quotient", longint'(quotient), longint'(got_q));
    check(done == 1'b0, "R8", "no stray done", longint'(done), 0);

    // R7: start while busy ignored
    run_div(32'd50000, 16'd25, 1'b1);
    check_value(32'd50000, 16'd25, "R7");
    begin
      int extra = 0;
      for (int k = 0; k < 15; k++) begin
        @(negedge clk);
        if (done) extra++;
      end
      check(extra == 0, "R7", "extra done pulses", extra, 0);
      check(quotient == got_q, "R7", "quotient kept", longint'(quotient), longint'(got_q));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule